// File: doc/BRIEF.md
# Complementary Gate Pair Generator with Dead Time

This block drives the upper and lower switches of the legs of a two-level inverter. A shared triangular carrier counts up and down between zero and a programmable turning value. Each leg compares its own signed modulation word with that carrier and forms an ideal upper-switch level. The upper switch is off while the scaled modulation is above the carrier. The ideal lower-switch level is the inverse of the upper one.

Before either gate is driven, every transition of the ideal level is followed by a programmable interval in which both gates of the leg are held off. The high pulse of each gate is therefore trimmed by that interval. If the ideal level flips again before the interval ends, the interval starts over. As a result, the upper and lower switches of a leg cannot conduct at the same moment. One instance with the default channel count covers a three-phase bridge.

Top module: `pwm_deadband_top`

## Requirements
- R1: The carrier moves by exactly one count per clock, from 0 up to P and back down to 0, and so repeats every 2P clocks. P is taken from `period_in` only in a cycle where the carrier is 0. With P = 0 the carrier stays at 0.
- R2: The threshold of a channel is ((m + 2^(CW-1)) * P) >> CW, where m is its CW-bit two's-complement slice `mod_in[ch*CW +: CW]`. It is captured together with P in a carrier-0 cycle and is held constant until the next one.
- R3: The ideal upper level is 1 when carrier >= threshold and 0 otherwise, so the upper gate is off while the threshold exceeds the carrier. The ideal lower level is its inverse. A gate is high only if its ideal level was high one cycle earlier.
- R4: For a channel, `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R5: A gate's high pulse is its ideal run length minus D clocks, where D is `dead_in`. A run of D clocks or fewer gives no pulse. Each gate falls one clock after its ideal level, and stays low for D clocks before the opposite gate rises.
- R6: A change of the ideal level during the dead interval restarts the interval. No gate rises until the ideal level has been stable for D clocks.
- R7: With D = 0, the gates equal the ideal levels delayed by one clock and are exact complements.
- R8: While `rst` is high at a clock edge, both gates of every channel go low and the carrier goes to 0.
- R9: Channels share the carrier and P but use their own modulation slice and dead-time state, so each channel's duty follows only its own slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_in | input | NCH*CW | Signed modulation words, one CW-bit slice per channel |
| period_in | input | CW | Carrier turning value P |
| dead_in | input | DW | Dead interval D in clocks |
| gate_hi | output | NCH | Upper-switch gates, one bit per channel |
| gate_lo | output | NCH | Lower-switch gates, one bit per channel |

## Verification
The directed patterns use a fixed P with three channels at different modulation values, one of which is the most negative code.

- With D = 0 and then D = 4, the per-period high counts separate correct threshold scaling and comparison direction from trimming by the dead interval.
- A modulation near full scale, with D longer than the resulting upper pulse, shows whether the dead counter restarts or leaks a runt pulse.
- P = 0 tests the frozen-carrier case.

Random segments vary P, D, the modulation words and resets mid-period. They are compared clock by clock against a bench model of the carrier, threshold capture and dead-time rule.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_in,
  output logic [CW-1:0] cnt_o,
  output logic          at_min_o
);
  import pwm_db_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] per_q;
  dir_e          dir_q;
  logic          past_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      per_q     <= '0;
      dir_q     <= DIR_UP;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      if (cnt_q == '0) begin
        per_q <= period_in;
        dir_q <= DIR_UP;
        cnt_q <= (period_in == '0) ? '0 : CW'(1);
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= per_q) begin
          cnt_q <= cnt_q - 1'b1;
          dir_q <= DIR_DOWN;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign at_min_o = (cnt_q == '0);

  // R1: carrier never leaves [0, P]
  assert_carrier_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_q);

  // R1: unit step per clock, or rest at zero
  assert_carrier_step_R1: assert property (@(posedge clk) disable iff (rst)
    past_ok_q |-> ((cnt_q == $past(cnt_q) + 1'b1) ||
                   ($past(cnt_q) == cnt_q + 1'b1) ||
                   (cnt_q == '0 && $past(cnt_q) == '0)));

  // R8: carrier starts from zero after reset
  assert_carrier_reset_R8: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_leg_compare.sv
module pwm_leg_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] mod_in,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] cnt_i,
  input  logic          at_min_i,
  output logic          ideal_o
);
  localparam int PW = 2 * CW;

  logic [CW-1:0] ofs;
  logic [PW-1:0] prod;
  logic [CW-1:0] thr_nx;
  logic [CW-1:0] thr_q;

  // offset-binary form of the signed word, then scale to [0, P)
  always_comb begin
    ofs    = {~mod_in[CW-1], mod_in[CW-2:0]};
    prod   = {{CW{1'b0}}, ofs} * {{CW{1'b0}}, period_in};
    thr_nx = CW'(prod >> CW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
    end else if (at_min_i) begin
      thr_q <= thr_nx;
    end
  end

  assign ideal_o = (cnt_i >= thr_q);

  // R2: threshold only moves at the carrier minimum
  assert_thr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !at_min_i |=> $stable(thr_q));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ideal_i,
  input  logic [DW-1:0]          dead_in,
  output pwm_db_pkg::gate_pair_t gate_o
);
  import pwm_db_pkg::*;

  logic          last_q;
  logic [DW-1:0] dc_q;
  logic [DW-1:0] dc_nx;
  logic          quiet;
  gate_pair_t    gate_q;
  logic          past_ok_q;

  always_comb begin
    if (ideal_i != last_q) begin
      dc_nx = dead_in;
    end else if (dc_q != '0) begin
      dc_nx = dc_q - 1'b1;
    end else begin
      dc_nx = '0;
    end
    quiet = (dc_nx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= 1'b0;
      dc_q      <= '0;
      gate_q    <= '0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      last_q    <= ideal_i;
      dc_q      <= dc_nx;
      gate_q.hi <= ideal_i & quiet;
      gate_q.lo <= ~ideal_i & quiet;
    end
  end

  assign gate_o = gate_q;

  // R4: no shoot-through
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(gate_q.hi && gate_q.lo));

  // R3: a gate is only high when its ideal level was high
  assert_hi_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && gate_q.hi) |-> $past(ideal_i));

  assert_lo_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && gate_q.lo) |-> !$past(ideal_i));

  // R6: with a nonzero dead interval, a gate only rises out of an all-off cycle
  assert_rise_after_dead_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && ($rose(gate_q.hi) || $rose(gate_q.lo)) && ($past(dead_in) != '0))
      |-> $past(!gate_q.hi && !gate_q.lo));

  // R8: reset turns both gates off
  assert_gate_reset_R8: assert property (@(posedge clk)
    rst |=> (!gate_q.hi && !gate_q.lo));

endmodule

// File: rtl/pwm_deadband_top.sv
module pwm_deadband_top #(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH*CW-1:0] mod_in,
  input  logic [CW-1:0]    period_in,
  input  logic [DW-1:0]    dead_in,
  output logic [NCH-1:0]   gate_hi,
  output logic [NCH-1:0]   gate_lo
);
  import pwm_db_pkg::*;

  logic [CW-1:0] carrier;
  logic          at_min;

  pwm_carrier #(.CW(CW)) carrier_i (
    .clk       (clk),
    .rst       (rst),
    .period_in (period_in),
    .cnt_o     (carrier),
    .at_min_o  (at_min)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_leg
    logic       ideal;
    gate_pair_t pair;

    pwm_leg_compare #(.CW(CW)) cmp_i (
      .clk       (clk),
      .rst       (rst),
      .mod_in    (mod_in[ch*CW +: CW]),
      .period_in (period_in),
      .cnt_i     (carrier),
      .at_min_i  (at_min),
      .ideal_o   (ideal)
    );

    pwm_deadband #(.DW(DW)) db_i (
      .clk     (clk),
      .rst     (rst),
      .ideal_i (ideal),
      .dead_in (dead_in),
      .gate_o  (pair)
    );

    assign gate_hi[ch] = pair.hi;
    assign gate_lo[ch] = pair.lo;
  end

endmodule

// File: tb/pwm_deadband_top_tb_top.sv
module pwm_deadband_top_tb_top;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH*CW-1:0] mod_in = '0;
  logic [CW-1:0]     period_in = '0;
  logic [DW-1:0]     dead_in = '0;
  logic [NCH-1:0]    gate_hi;
  logic [NCH-1:0]    gate_lo;

  always #4 clk = ~clk;

  pwm_deadband_top #(.NCH(NCH), .CW(CW), .DW(DW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mod_in    (mod_in),
    .period_in (period_in),
    .dead_in   (dead_in),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int scale_thr(input int m, input int p);
    longint u;
    u = longint'(m) + (longint'(1) << (CW - 1));
    return int'((u * longint'(p)) >>> CW);
  endfunction

  // reference model, advanced once per clock from the requirements
  int mc = 0, mper = 0;
  bit mup = 1;
  int mthr  [NCH];
  bit mlast [NCH];
  int mdc   [NCH];
  bit mhi   [NCH];
  bit mlo   [NCH];

  always @(negedge clk) begin : model
    bit id [NCH];
    int dn;
    for (int ch = 0; ch < NCH; ch++) id[ch] = (mc >= mthr[ch]);
    if (rst) begin
      mc = 0; mper = 0; mup = 1;
      for (int ch = 0; ch < NCH; ch++) begin
        mthr[ch] = 0; mlast[ch] = 0; mdc[ch] = 0; mhi[ch] = 0; mlo[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (id[ch] != mlast[ch]) dn = int'(dead_in);
        else if (mdc[ch] > 0) dn = mdc[ch] - 1;
        else dn = 0;
        mlast[ch] = id[ch];
        mdc[ch]   = dn;
        mhi[ch]   = id[ch] && (dn == 0);
        mlo[ch]   = !id[ch] && (dn == 0);
      end
      if (mc == 0) begin
        for (int ch = 0; ch < NCH; ch++)
          mthr[ch] = scale_thr(int'($signed(mod_in[ch*CW +: CW])), int'(period_in));
        mper = int'(period_in);
        mup  = 1;
        mc   = (period_in == '0) ? 0 : 1;
      end else if (mup) begin
        if (mc >= mper) begin mc = mc - 1; mup = 0; end
        else mc = mc + 1;
      end else begin
        mc = mc - 1;
      end
    end
    if (!done) begin
      for (int ch = 0; ch < NCH; ch++) begin
        // R3/R5/R6: per-cycle gate levels against the model
        check(gate_hi[ch] == mhi[ch], "R5", "gate_hi vs model", int'(gate_hi[ch]), int'(mhi[ch]));
        check(gate_lo[ch] == mlo[ch], "R6", "gate_lo vs model", int'(gate_lo[ch]), int'(mlo[ch]));
        // R4: never both on
        check(!(gate_hi[ch] && gate_lo[ch]), "R4", "overlap", 1, 0);
      end
    end
  end

  task automatic set_mod(input int m0, input int m1, input int m2);
    mod_in = {CW'(m2), CW'(m1), CW'(m0)};
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic count_win(input int ncyc, output int hi [NCH], output int lo [NCH]);
    for (int ch = 0; ch < NCH; ch++) begin hi[ch] = 0; lo[ch] = 0; end
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk); #2;
      for (int ch = 0; ch < NCH; ch++) begin
        hi[ch] += int'(gate_hi[ch]);
        lo[ch] += int'(gate_lo[ch]);
      end
    end
    #1;
  endtask

  function automatic int exp_hi(input int thr, input int p, input int d);
    int run;
    run = (thr == 0) ? 2 * p : 2 * (p - thr) + 1;
    if (thr == 0) return run;
    return (run > d) ? run - d : 0;
  endfunction

  function automatic int exp_lo(input int thr, input int p, input int d);
    int run;
    if (thr == 0) return 0;
    run = 2 * thr - 1;
    return (run > d) ? run - d : 0;
  endfunction

  initial begin : stim
    int hi [NCH];
    int lo [NCH];
    int thr [NCH];
    int mv [NCH];
    int p, d, hold;
    int unused_seed;
    unused_seed = $urandom(32'd20240611);

    // R8: reset holds gates off
    period_in = CW'(50); dead_in = '0;
    step(4);
    check(gate_hi == '0 && gate_lo == '0, "R8", "gates during reset",
          int'({gate_hi, gate_lo}), 0);
    rst = 1'b0;

    // R2/R3/R7/R9: distinct channels, no dead time
    mv[0] = -6553; mv[1] = 19661; mv[2] = -32768;
    set_mod(mv[0], mv[1], mv[2]);
    p = 50; d = 0;
    for (int ch = 0; ch < NCH; ch++) thr[ch] = scale_thr(mv[ch], p);
    check(thr[0] == 20 && thr[1] == 40 && thr[2] == 0, "R2", "bench scaling",
          thr[0], 20);
    step(300);
    count_win(2 * p, hi, lo);
    for (int ch = 0; ch < NCH; ch++) begin
      check(hi[ch] == exp_hi(thr[ch], p, d), "R7", "hi count D=0", hi[ch], exp_hi(thr[ch], p, d));
      check(lo[ch] == exp_lo(thr[ch], p, d), "R9", "lo count D=0", lo[ch], exp_lo(thr[ch], p, d));
    end
    check(hi[0] + lo[0] == 2 * p, "R1", "period length D=0", hi[0] + lo[0], 2 * p);

    // R5: dead interval trims both pulses
    dead_in = DW'(4); d = 4;
    step(300);
    count_win(2 * p, hi, lo);
    for (int ch = 0; ch < NCH; ch++) begin
      check(hi[ch] == exp_hi(thr[ch], p, d), "R5", "hi count D=4", hi[ch], exp_hi(thr[ch], p, d));
      check(lo[ch] == exp_lo(thr[ch], p, d), "R5", "lo count D=4", lo[ch], exp_lo(thr[ch], p, d));
    end
    check(hi[0] + lo[0] == 2 * p - 2 * d, "R5", "two dead gaps", hi[0] + lo[0], 2 * p - 2 * d);

    // R6: short ideal pulse inside the dead interval restarts it
    p = 20; period_in = CW'(20); dead_in = DW'(5); d = 5;
    mv[0] = 29492; set_mod(mv[0], mv[1], mv[2]);
    thr[0] = scale_thr(mv[0], p);
    step(300);
    count_win(2 * p, hi, lo);
    check(thr[0] == 19, "R2", "bench scaling near full", thr[0], 19);
    check(hi[0] == 0, "R6", "runt upper pulse suppressed", hi[0], 0);
    check(lo[0] == 2 * thr[0] - 1 - d, "R6", "lower pulse after restart", lo[0], 2 * thr[0] - 1 - d);

    // R1: P = 0 freezes the carrier at 0 -> threshold 0 -> upper on
    period_in = '0;
    step(200);
    count_win(16, hi, lo);
    for (int ch = 0; ch < NCH; ch++)
      check(hi[ch] == 16 && lo[ch] == 0, "R1", "frozen carrier", hi[ch], 16);

    // random segments, checked per cycle by the model
    for (int seg = 0; seg < 40; seg++) begin
      period_in = CW'(2 + ($urandom % 63));
      dead_in   = DW'($urandom % 10);
      mod_in    = {CW'($urandom), CW'($urandom), CW'($urandom)};
      hold      = 200 + ($urandom % 600);
      if (($urandom % 8) == 0) begin
        rst = 1'b1; step(1 + ($urandom % 3)); rst = 1'b0;
      end
      step(hold);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(8 * 190000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule